// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block turns the single-bit output of a consumer-infrared demodulating receiver into a stream of 8-bit run-length symbols, ready to be pushed into a FIFO. The receiver output is brought into the clock domain by a two-flop synchroniser. It can then be inverted, and it is sampled on a tick derived from the module clock by a fixed divider. A glitch filter rejects level changes shorter than a programmable number of samples. Each run of constant level that survives is reported as one symbol. The top bit of the symbol gives the level, and the low seven bits give the run length in samples minus one. Runs longer than 128 samples are split into several symbols.

An idle detector watches the space (inactive) level. Once the space has lasted `(idle_thr + 1) * 128` samples, the packet is over: a one-cycle `pkt_end` pulse is raised together with the last space symbol. After that the encoder stays silent until a pulse is seen again. Both enables must be high for the block to run. Dropping either one discards any partial run and returns the encoder to its idle state.

Top module: `ir_runlen_enc`

## Requirements
- R1: A sample is taken once every `PRESCALE` clock cycles while enabled (default 64). A level held for N·`PRESCALE` cycles counts as N samples, and two emitted symbols are always at least one sample period apart.
- R2: Each symbol on `sym_data` carries the level in bit 7 (1 = pulse, 0 = space) and the run length in samples minus one in bits 6:0. `sym_valid` is high for exactly one cycle per symbol.
- R3: When a run reaches 128 samples, the symbol {level, 127} is emitted and counting of the same level restarts from zero. A run of 129 samples therefore gives {level,127} followed by {level,0}.
- R4: With `invert` high, the synchronised input is inverted before sampling, so a low raw input counts as a pulse.
- R5: A new level is accepted only after it has been sampled on `noise_thr` consecutive ticks (a value of 0 acts as 1). A shorter excursion is merged into the surrounding run, and an accepted run keeps its full length.
- R6: When a space has lasted `(idle_thr + 1) * 128` samples, `pkt_end` pulses for one cycle. It coincides with the final space symbol {0,127}. A space one sample shorter than the limit raises no `pkt_end`.
- R7: While `glb_en` or `rx_en` is low, no symbol and no `pkt_end` is produced. On re-enable the encoder starts idle, with any partial run discarded.
- R8: In the idle state (after reset, after `pkt_end`, after re-enable), space samples produce no symbols. Encoding resumes with the first accepted pulse.
- R9: After reset, `sym_valid` and `pkt_end` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| invert | input | 1 | Invert input polarity |
| noise_thr | input | NOISE_W (6) | Minimum accepted run length in samples |
| idle_thr | input | IDLE_W (8) | Idle limit is (idle_thr+1)*128 space samples |
| ir_in | input | 1 | Asynchronous receiver output |
| sym_valid | output | 1 | Symbol strobe toward the FIFO |
| sym_data | output | 8 | Symbol: level in bit 7, length-1 in bits 6:0 |
| pkt_end | output | 1 | One-cycle end-of-packet pulse |

## Verification
A wrong run counter shows up at once in the length field of the next symbol. A wrong saturation point shows up as extra or missing {level,127} symbols within 128 samples of the run start. A filter that lets a short excursion through splits a merged run into three symbols at the next accepted edge. A stuck idle flag shows either as space symbols after `pkt_end` or as a missing `pkt_end` once the idle limit has passed. The bench therefore compares complete symbol streams, with `pkt_end` marks, against sequences built from run lengths. It sweeps every pulse length around the saturation boundary.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
    localparam int RUN_W = 7;
    localparam int SYM_W = RUN_W + 1;
    localparam int RUN_LEN = 1 << RUN_W;

    typedef struct packed {
        logic               pulse;
        logic [RUN_W-1:0]   len_m1;
    } sym_t;
endpackage

// File: rtl/ir_rle_presc.sv
module ir_rle_presc #(
    parameter int PRESCALE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = active && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!active || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESCALE > 1 && tick) |=> !tick); // R1
endmodule

// File: rtl/ir_rle_filter.sv
module ir_rle_filter #(
    parameter int NOISE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               tick,
    input  logic               invert,
    input  logic [NOISE_W-1:0] noise_thr,
    input  logic               ir_in,
    output logic               lvl_next
);
    typedef struct packed {
        logic               s1;
        logic               s2;
        logic               filt;
        logic [NOISE_W-1:0] cand;
    } flt_t;

    flt_t st_d, st_q;
    logic smp;
    logic [NOISE_W:0] cand_inc;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = ir_in;
        st_d.s2  = st_q.s1;
        smp      = st_q.s2 ^ invert;
        cand_inc = {1'b0, st_q.cand} + 1'b1;
        if (!active) begin
            st_d.filt = 1'b0;
            st_d.cand = '0;
        end else if (tick) begin
            if (smp == st_q.filt) begin
                st_d.cand = '0;
            end else if (cand_inc >= {1'b0, noise_thr}) begin
                st_d.filt = smp;
                st_d.cand = '0;
            end else begin
                st_d.cand = cand_inc[NOISE_W-1:0];
            end
        end
        lvl_next = st_d.filt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FILT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(st_q.filt)); // R5
endmodule

// File: rtl/ir_rle_runner.sv
module ir_rle_runner
    import ir_rle_pkg::*;
#(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic              lvl,
    input  logic [IDLE_W-1:0] idle_thr,
    output logic              sym_valid,
    output sym_t              sym,
    output logic              pkt_end
);
    localparam int SP_W = IDLE_W + RUN_W + 1;

    typedef struct packed {
        logic             idle;
        logic             lvl;
        logic [RUN_W:0]   cnt;
        logic [SP_W-1:0]  sp;
        logic             v;
        sym_t             sym;
        logic             pe;
    } run_t;

    run_t st_d, st_q;
    logic [RUN_W:0]  cnt_inc;
    logic [SP_W-1:0] sp_inc;
    logic [SP_W-1:0] limit;

    always_comb begin
        limit   = (SP_W'(idle_thr) + SP_W'(1)) << RUN_W;
        cnt_inc = st_q.cnt + 1'b1;
        sp_inc  = st_q.sp + 1'b1;
        st_d    = st_q;
        st_d.v  = 1'b0;
        st_d.pe = 1'b0;
        if (!active) begin
            st_d      = '0;
            st_d.idle = 1'b1;
        end else if (tick) begin
            if (st_q.idle) begin
                if (lvl) begin
                    st_d.idle = 1'b0;
                    st_d.lvl  = 1'b1;
                    st_d.cnt  = (RUN_W+1)'(1);
                    st_d.sp   = '0;
                end
            end else if (lvl != st_q.lvl) begin
                if (st_q.cnt != '0) begin
                    st_d.v          = 1'b1;
                    st_d.sym.pulse  = st_q.lvl;
                    st_d.sym.len_m1 = RUN_W'(st_q.cnt - 1'b1);
                end
                st_d.lvl = lvl;
                st_d.cnt = (RUN_W+1)'(1);
                st_d.sp  = lvl ? '0 : SP_W'(1);
            end else begin
                if (cnt_inc == (RUN_W+1)'(RUN_LEN)) begin
                    st_d.v          = 1'b1;
                    st_d.sym.pulse  = st_q.lvl;
                    st_d.sym.len_m1 = '1;
                    st_d.cnt        = '0;
                end else begin
                    st_d.cnt = cnt_inc;
                end
                if (!st_q.lvl) begin
                    st_d.sp = sp_inc;
                    if (sp_inc == limit) begin
                        st_d.pe   = 1'b1;
                        st_d.idle = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.idle <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sym_valid = st_q.v;
    assign sym       = st_q.sym;
    assign pkt_end   = st_q.pe;

    AST_SYM_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v |-> $past(tick)); // R1
    AST_IDLE_NO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && st_q.idle && !lvl) |=> !st_q.v); // R8
endmodule

// File: rtl/ir_runlen_enc.sv
module ir_runlen_enc
    import ir_rle_pkg::*;
#(
    parameter int PRESCALE = 64,
    parameter int NOISE_W  = 6,
    parameter int IDLE_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic               rx_en,
    input  logic               invert,
    input  logic [NOISE_W-1:0] noise_thr,
    input  logic [IDLE_W-1:0]  idle_thr,
    input  logic               ir_in,
    output logic               sym_valid,
    output logic [SYM_W-1:0]   sym_data,
    output logic               pkt_end
);
    logic active;
    logic tick;
    logic lvl_next;
    sym_t sym;

    assign active = glb_en & rx_en;

    ir_rle_presc #(.PRESCALE(PRESCALE)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .tick   (tick)
    );

    ir_rle_filter #(.NOISE_W(NOISE_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tick      (tick),
        .invert    (invert),
        .noise_thr (noise_thr),
        .ir_in     (ir_in),
        .lvl_next  (lvl_next)
    );

    ir_rle_runner #(.IDLE_W(IDLE_W)) u_runner (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tick      (tick),
        .lvl       (lvl_next),
        .idle_thr  (idle_thr),
        .sym_valid (sym_valid),
        .sym       (sym),
        .pkt_end   (pkt_end)
    );

    assign sym_data = sym;

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!sym_valid && !pkt_end)); // R7
    AST_PKT_WITH_SPACE_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> (sym_valid && sym_data == {1'b0, {RUN_W{1'b1}}})); // R6
endmodule

// File: tb/tb_ir_runlen_enc.sv
module tb_ir_runlen_enc;
    localparam int P = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glb_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       invert = 1'b0;
    logic [5:0] noise_thr = 6'd1;
    logic [7:0] idle_thr = 8'd0;
    logic       ir_in = 1'b0;
    logic       sym_valid;
    logic [7:0] sym_data;
    logic       pkt_end;

    int vecs = 0;
    int fails = 0;
    int cyc = 0;
    bit inv_b = 1'b0;
    logic [9:0] got[$];
    logic [9:0] expq[$];
    int gt[$];

    always #2.5 clk = ~clk;

    ir_runlen_enc #(.PRESCALE(P)) dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rx_en(rx_en),
        .invert(invert), .noise_thr(noise_thr), .idle_thr(idle_thr),
        .ir_in(ir_in), .sym_valid(sym_valid), .sym_data(sym_data),
        .pkt_end(pkt_end)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (sym_valid || pkt_end) begin
            got.push_back({sym_valid, pkt_end, sym_data});
            gt.push_back(cyc);
        end
    end

    task automatic drive(input bit lvl, input int n);
        @(negedge clk);
        ir_in = lvl ^ inv_b;
        repeat (n * P - 1) @(negedge clk);
    endtask

    task automatic exp_run(input bit lvl, input int len, input bit end_pkt);
        int rem = len;
        while (rem > 0) begin
            int c = (rem > 128) ? 128 : rem;
            rem -= c;
            expq.push_back({1'b1, (end_pkt && rem == 0), lvl, 7'(c - 1)});
        end
    endtask

    task automatic check(input string tag);
        repeat (8 * P) @(negedge clk);
        vecs++;
        if (got.size() != expq.size()) begin
            fails++;
            $display("FAIL %s: symbol count %0d expected %0d", tag, got.size(), expq.size());
        end
        for (int i = 0; i < got.size() && i < expq.size(); i++) begin
            vecs++;
            if (got[i] !== expq[i]) begin
                fails++;
                $display("FAIL %s: entry %0d got %h expected %h", tag, i, got[i], expq[i]);
            end
        end
        got.delete();
        expq.delete();
        gt.delete();
    endtask

    task automatic set_enables(input bit g, input bit r);
        @(negedge clk);
        glb_en = g;
        rx_en  = r;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vecs++;
        if (sym_valid !== 1'b0 || pkt_end !== 1'b0) begin
            fails++;
            $display("FAIL R9: reset outputs got %b%b expected 00", sym_valid, pkt_end);
        end
        set_enables(1, 1);
        drive(0, 10);
        got.delete(); gt.delete();

        // R2 / R3 / R1: sweep pulse lengths across the saturation boundary
        for (int L = 1; L <= 135; L++) begin
            drive(1, L);
            drive(0, 128 + 6);
            exp_run(1, L, 0);
            exp_run(0, 128, 1);
            if (L == 128) begin
                vecs++;
                if (gt.size() < 2 || gt[1] - gt[0] != 128 * P) begin
                    fails++;
                    $display("FAIL R1: saturated symbol spacing got %0d expected %0d",
                             (gt.size() < 2) ? -1 : gt[1] - gt[0], 128 * P);
                end
            end
            check((L >= 128) ? "R3" : "R2");
        end

        // R3: multiples of the saturation length
        drive(1, 256); drive(0, 134);
        exp_run(1, 256, 0); exp_run(0, 128, 1);
        check("R3");
        drive(1, 257); drive(0, 134);
        exp_run(1, 257, 0); exp_run(0, 128, 1);
        check("R3");

        // R2 / R8: multi-run packet with a longer idle limit, then long silence
        idle_thr = 8'd2;
        drive(1, 9); drive(0, 4); drive(1, 130); drive(0, 200); drive(1, 3);
        drive(0, 384 + 300);
        exp_run(1, 9, 0); exp_run(0, 4, 0); exp_run(1, 130, 0);
        exp_run(0, 200, 0); exp_run(1, 3, 0); exp_run(0, 384, 1);
        check("R8");

        // R6: space one sample short of the limit, then exactly the limit
        idle_thr = 8'd1;
        drive(1, 4); drive(0, 255); drive(1, 4); drive(0, 256 + 6);
        exp_run(1, 4, 0); exp_run(0, 255, 0); exp_run(1, 4, 0); exp_run(0, 256, 1);
        check("R6");

        // R5: noise threshold 3
        idle_thr  = 8'd0;
        noise_thr = 6'd3;
        drive(0, 20); drive(1, 2); drive(0, 20);
        drive(1, 10); drive(0, 2); drive(1, 10); drive(0, 3); drive(1, 5);
        drive(0, 134);
        exp_run(1, 22, 0); exp_run(0, 3, 0); exp_run(1, 5, 0); exp_run(0, 128, 1);
        check("R5");
        noise_thr = 6'd0;
        drive(1, 1); drive(0, 1); drive(1, 1); drive(0, 134);
        exp_run(1, 1, 0); exp_run(0, 1, 0); exp_run(1, 1, 0); exp_run(0, 128, 1);
        check("R5");
        noise_thr = 6'd1;

        // R4: inverted input polarity
        set_enables(1, 0);
        invert = 1'b1; inv_b = 1'b1; ir_in = 1'b1;
        repeat (4) @(negedge clk);
        set_enables(1, 1);
        drive(1, 20); drive(0, 134);
        exp_run(1, 20, 0); exp_run(0, 128, 1);
        check("R4");
        set_enables(1, 0);
        invert = 1'b0; inv_b = 1'b0; ir_in = 1'b0;
        repeat (4) @(negedge clk);

        // R7: gating by each enable
        drive(1, 30); drive(0, 5); drive(1, 30); drive(0, 10);
        set_enables(0, 1);
        drive(1, 30); drive(0, 5); drive(1, 200); drive(0, 10);
        check("R7");
        set_enables(1, 1);
        drive(1, 50);
        set_enables(1, 0);
        drive(1, 10); drive(0, 4);
        set_enables(1, 1);
        drive(0, 200);
        check("R7");
        drive(1, 7); drive(0, 134);
        exp_run(1, 7, 0); exp_run(0, 128, 1);
        check("R7");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule